// File: doc/BRIEF.md
# Codec-Side Serial Audio Link Frame Engine

This block is the codec end of a 48 kHz time-slotted serial audio link. It runs on the bit clock supplied with the link. A rising edge on the frame-sync line opens a 256-bit frame. The frame holds a 16-bit tag slot and then twelve 20-bit slots. From the incoming serial stream the engine extracts the tag, a command address, command write data and two playback PCM words. It turns these into single-cycle strobes on a register-bus port and on two DAC ports.

In the other direction the engine builds the outgoing serial stream. That stream carries a status tag, the echo of a register read, and left and right record samples. A read requested in one frame is answered in the frame that follows. The register file, the converters and the bit-clock source sit outside this block.

Top module: `aclink_codec_engine`

## Requirements
- R1: A frame starts at the first rising clock edge at which `sync` is high after being low. The first outgoing bit (tag bit 15) appears on `sdataIn` from that edge. Before any frame has started, `sdataIn` is 0.
- R2: `sdataOut` is sampled on the falling edge of `bitClk`. A frame is 256 bits, MSB first: a 16-bit tag, then slots 1 to 12 of 20 bits each. Slot k covers frame bits 16+20(k-1) to 35+20(k-1).
- R3: Incoming slots 1 to 4 are acted on only when tag bit 15 (frame valid) is 1 and the slot's own tag bit is 1. The tag bits are bit 14 for slot 1, bit 13 for slot 2, bit 12 for slot 3 and bit 11 for slot 4. Otherwise the slot causes no strobe.
- R4: `regWrEn` pulses for one cycle, with `regAddr` = slot 1 bits 18..12 and `regWrData` = slot 2 bits 19..4, only when slot 1 bit 19 is 0 and slots 1 and 2 are both valid. A slot 1 with bit 19 set never writes.
- R5: A valid slot 1 with bit 19 = 1 gives a one-cycle `regRdEn` pulse with `regAddr` = slot 1 bits 18..12. `regRdData` is taken at the clock edge that ends that cycle.
- R6: The following outgoing frame, and only that frame, sets tag bits 14 and 13. It carries the read index in slot 1 bits 18..12 and the read data in slot 2 bits 19..4.
- R7: When no read is pending, outgoing tag bits 14 and 13 are 0, and outgoing slots 1 and 2 are all zero.
- R8: For a valid slot 3 (left) or slot 4 (right), the DAC port receives slot bits 19..2 as an 18-bit word, with a one-cycle strobe.
- R9: Outgoing tag bit 15 equals `codecReady` at the frame start. Tag bits 12 and 11 equal `recValid`. Slots 3 and 4 hold `recLeft` and `recRight` in bits 19..2 when `recValid` is 1, and are zero otherwise.
- R10: Outgoing tag bits 10..0, all other reserved slot bits, and slots 5 to 12 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Link bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame sync from the controller |
| sdataOut | input | 1 | Serial stream from the controller |
| sdataIn | output | 1 | Serial stream to the controller |
| codecReady | input | 1 | Ready flag reported in the outgoing tag |
| recValid | input | 1 | Record samples valid |
| recLeft | input | 18 | Left record sample |
| recRight | input | 18 | Right record sample |
| regAddr | output | 7 | Register index of the current command |
| regWrEn | output | 1 | Register write strobe |
| regWrData | output | 16 | Register write data |
| regRdEn | output | 1 | Register read strobe |
| regRdData | input | 16 | Register read data, valid while regRdEn is high |
| dacLeft | output | 18 | Left playback word |
| dacLeftStb | output | 1 | Left playback strobe |
| dacRight | output | 18 | Right playback word |
| dacRightStb | output | 1 | Right playback strobe |

## Verification
The assertions check properties that hold on every cycle. Outgoing data stays quiet until the first sync. Write and read strobes never coincide and each lasts one cycle. The DAC strobes are single pulses. The register index holds steady under a write. Only the directed frames can show the contents of each slot. These scenarios cover tag gating, rejection of a write when the read flag is set, the single-frame lifetime of a read echo, the ready and record flags, and the zero fill of the reserved slots.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  // Strobes from the frame controller to the datapath.
  typedef struct packed {
    logic frameStart;
    logic rxTake;
    logic tagDone;
    logic cmdAddrDone;
    logic cmdDataDone;
    logic leftDone;
    logic rightDone;
    logic txOn;
  } linkStrobes_t;
endpackage

// File: rtl/aclink_frame_ctrl.sv
module aclink_frame_ctrl
  import aclink_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W,
  localparam int CNT_W    = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sync,
  output linkStrobes_t     stb,
  output logic [CNT_W-1:0] txIdx
);
  localparam int LAST      = FRAME_W - 1;
  localparam int TAG_END   = TAG_W - 1;
  localparam int ADDR_END  = TAG_END + SLOT_W;
  localparam int DATA_END  = TAG_END + 2 * SLOT_W;
  localparam int LEFT_END  = TAG_END + 3 * SLOT_W;
  localparam int RIGHT_END = TAG_END + 4 * SLOT_W;

  logic             syncPrev;
  logic             active;
  logic [CNT_W-1:0] bitCnt;
  logic             startNow;

  assign startNow = sync & ~syncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      active   <= 1'b0;
      bitCnt   <= '0;
    end else begin
      syncPrev <= sync;
      if (startNow) begin
        active <= 1'b1;
        bitCnt <= '0;
      end else if (active) begin
        if (bitCnt == CNT_W'(LAST)) active <= 1'b0;
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.frameStart  = startNow;
    stb.rxTake      = active;
    stb.tagDone     = active && (bitCnt == CNT_W'(TAG_END));
    stb.cmdAddrDone = active && (bitCnt == CNT_W'(ADDR_END));
    stb.cmdDataDone = active && (bitCnt == CNT_W'(DATA_END));
    stb.leftDone    = active && (bitCnt == CNT_W'(LEFT_END));
    stb.rightDone   = active && (bitCnt == CNT_W'(RIGHT_END));
    stb.txOn        = startNow || (active && (bitCnt != CNT_W'(LAST)));
    txIdx           = startNow ? '0 : bitCnt + 1'b1;
  end
endmodule

// File: rtl/aclink_datapath.sv
module aclink_datapath
  import aclink_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int PCM_W     = 18,
  localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W,
  localparam int CNT_W    = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrobes_t      stb,
  input  logic [CNT_W-1:0]  txIdx,
  input  logic              sdataOut,
  output logic              sdataIn,
  input  logic              codecReady,
  input  logic              recValid,
  input  logic [PCM_W-1:0]  recLeft,
  input  logic [PCM_W-1:0]  recRight,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData,
  output logic [PCM_W-1:0]  dacLeft,
  output logic              dacLeftStb,
  output logic [PCM_W-1:0]  dacRight,
  output logic              dacRightStb
);
  localparam int ADDR_PAD = SLOT_W - 1 - ADDR_W;
  localparam int DATA_PAD = SLOT_W - DATA_W;
  localparam int PCM_PAD  = SLOT_W - PCM_W;
  localparam int TAG_PAD  = TAG_W - 5;

  // Falling-edge capture of the incoming serial bit.
  logic rxBit;
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rxBit <= 1'b0;
    else       rxBit <= sdataOut;
  end

  logic [SLOT_W-1:0] rxShift, shiftNext;
  logic [4:0]        rxTag;   // frame valid, slot1..slot4 valid
  logic              cmdRead, cmdOk;
  logic              readPend;
  logic [ADDR_W-1:0] pendAddr, echoAddr;
  logic [DATA_W-1:0] pendData, echoData;
  logic [PCM_W-1:0]  snapLeft, snapRight;
  logic [TAG_W-1:0]  txTag, tagNext, curTag;
  logic [SLOT_W-1:0] txSlot [1:4];
  logic              frameBit;

  assign shiftNext = {rxShift[SLOT_W-2:0], rxBit};
  assign tagNext   = {codecReady, readPend, readPend, recValid, recValid, {TAG_PAD{1'b0}}};
  assign curTag    = stb.frameStart ? tagNext : txTag;

  always_comb begin
    txSlot[1] = {1'b0, echoAddr, {ADDR_PAD{1'b0}}};
    txSlot[2] = {echoData, {DATA_PAD{1'b0}}};
    txSlot[3] = {snapLeft, {PCM_PAD{1'b0}}};
    txSlot[4] = {snapRight, {PCM_PAD{1'b0}}};
  end

  always_comb begin
    int idx;
    idx      = int'(txIdx);
    frameBit = 1'b0;
    if (idx < TAG_W) begin
      frameBit = curTag[TAG_W-1-idx];
    end else begin
      for (int k = 1; k <= 4; k++) begin
        if (idx >= TAG_W + (k-1)*SLOT_W && idx < TAG_W + k*SLOT_W)
          frameBit = txSlot[k][TAG_W + k*SLOT_W - 1 - idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift     <= '0;
      rxTag       <= '0;
      cmdRead     <= 1'b0;
      cmdOk       <= 1'b0;
      regAddr     <= '0;
      regWrEn     <= 1'b0;
      regWrData   <= '0;
      regRdEn     <= 1'b0;
      readPend    <= 1'b0;
      pendAddr    <= '0;
      pendData    <= '0;
      echoAddr    <= '0;
      echoData    <= '0;
      snapLeft    <= '0;
      snapRight   <= '0;
      txTag       <= '0;
      dacLeft     <= '0;
      dacLeftStb  <= 1'b0;
      dacRight    <= '0;
      dacRightStb <= 1'b0;
      sdataIn     <= 1'b0;
    end else begin
      regWrEn     <= 1'b0;
      regRdEn     <= 1'b0;
      dacLeftStb  <= 1'b0;
      dacRightStb <= 1'b0;

      if (stb.rxTake) rxShift <= shiftNext;
      if (stb.tagDone) rxTag <= shiftNext[TAG_W-1 -: 5];

      if (stb.cmdAddrDone) begin
        cmdRead <= shiftNext[SLOT_W-1];
        cmdOk   <= rxTag[4] & rxTag[3];
        regAddr <= shiftNext[SLOT_W-2 -: ADDR_W];
        regRdEn <= rxTag[4] & rxTag[3] & shiftNext[SLOT_W-1];
      end

      if (stb.cmdDataDone && cmdOk && !cmdRead && rxTag[2]) begin
        regWrData <= shiftNext[SLOT_W-1 -: DATA_W];
        regWrEn   <= 1'b1;
      end

      if (stb.leftDone && rxTag[4] && rxTag[1]) begin
        dacLeft    <= shiftNext[SLOT_W-1 -: PCM_W];
        dacLeftStb <= 1'b1;
      end
      if (stb.rightDone && rxTag[4] && rxTag[0]) begin
        dacRight    <= shiftNext[SLOT_W-1 -: PCM_W];
        dacRightStb <= 1'b1;
      end

      if (stb.frameStart) begin
        txTag     <= tagNext;
        echoAddr  <= readPend ? pendAddr : '0;
        echoData  <= readPend ? pendData : '0;
        snapLeft  <= recValid ? recLeft  : '0;
        snapRight <= recValid ? recRight : '0;
        readPend  <= 1'b0;
      end

      if (regRdEn) begin
        pendAddr <= regAddr;
        pendData <= regRdData;
        readPend <= 1'b1;
      end

      sdataIn <= stb.txOn ? frameBit : 1'b0;
    end
  end
endmodule

// File: rtl/aclink_codec_engine.sv
module aclink_codec_engine
  import aclink_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int PCM_W     = 18,
  localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W,
  localparam int CNT_W    = $clog2(FRAME_W)
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              sync,
  input  logic              sdataOut,
  output logic              sdataIn,
  input  logic              codecReady,
  input  logic              recValid,
  input  logic [PCM_W-1:0]  recLeft,
  input  logic [PCM_W-1:0]  recRight,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData,
  output logic [PCM_W-1:0]  dacLeft,
  output logic              dacLeftStb,
  output logic [PCM_W-1:0]  dacRight,
  output logic              dacRightStb
);
  linkStrobes_t     stb;
  logic [CNT_W-1:0] txIdx;

  aclink_frame_ctrl #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
  ) u_ctrl (
    .clk(bitClk), .rstN(rstN), .sync(sync), .stb(stb), .txIdx(txIdx)
  );

  aclink_datapath #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PCM_W(PCM_W)
  ) u_dp (
    .clk(bitClk), .rstN(rstN), .stb(stb), .txIdx(txIdx),
    .sdataOut(sdataOut), .sdataIn(sdataIn),
    .codecReady(codecReady), .recValid(recValid),
    .recLeft(recLeft), .recRight(recRight),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .dacLeft(dacLeft), .dacLeftStb(dacLeftStb),
    .dacRight(dacRight), .dacRightStb(dacRightStb)
  );
endmodule

// File: rtl/aclink_engine_checker.sv
module aclink_engine_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              sync,
  input logic              sdataIn,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              dacLeftStb,
  input logic              dacRightStb
);
  logic seenSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenSync <= 1'b0;
    else if (sync) seenSync <= 1'b1;
  end

  // R1: serial output stays low until the first frame sync
  p_idle_before_sync_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!seenSync && !sync) |=> !sdataIn);

  // R4, R5: write and read never strobe together
  p_wr_rd_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  // R4: write strobe lasts one cycle
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R4: register index steady while a write is issued
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $stable(regAddr));

  // R5: read strobe lasts one cycle
  p_rd_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  // R8: playback strobes are single pulses
  p_left_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    dacLeftStb |=> !dacLeftStb);
  p_right_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    dacRightStb |=> !dacRightStb);
endmodule

bind aclink_codec_engine aclink_engine_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(bitClk), .rstN(rstN), .sync(sync), .sdataIn(sdataIn),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .dacLeftStb(dacLeftStb), .dacRightStb(dacRightStb)
);

// File: tb/aclink_codec_engine_tb.sv
`timescale 1ns/1ps
module aclink_codec_engine_tb;
  logic        bitClk = 1'b0;
  logic        rstN = 1'b0;
  logic        sync = 1'b0;
  logic        sdataOut = 1'b0;
  logic        sdataIn;
  logic        codecReady = 1'b1;
  logic        recValid = 1'b0;
  logic [17:0] recLeft = '0, recRight = '0;
  logic [6:0]  regAddr;
  logic        regWrEn, regRdEn, dacLeftStb, dacRightStb;
  logic [15:0] regWrData, regRdData;
  logic [17:0] dacLeft, dacRight;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 bitClk = ~bitClk;   // 250 MHz

  function automatic logic [15:0] rdModel(input logic [6:0] a);
    return {~a, 2'b01, a};
  endfunction
  assign regRdData = rdModel(regAddr);

  aclink_codec_engine u_dut (
    .bitClk(bitClk), .rstN(rstN), .sync(sync), .sdataOut(sdataOut),
    .sdataIn(sdataIn), .codecReady(codecReady), .recValid(recValid),
    .recLeft(recLeft), .recRight(recRight), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .dacLeft(dacLeft), .dacLeftStb(dacLeftStb),
    .dacRight(dacRight), .dacRightStb(dacRightStb)
  );

  // Event monitors, sampled away from the active edge.
  int wrCount, rdCount, leftCount, rightCount;
  logic [6:0]  wrAddr, rdAddr;
  logic [15:0] wrData;
  logic [17:0] leftVal, rightVal;
  always @(negedge bitClk) begin
    if (regWrEn)     begin wrCount++; wrAddr = regAddr; wrData = regWrData; end
    if (regRdEn)     begin rdCount++; rdAddr = regAddr; end
    if (dacLeftStb)  begin leftCount++; leftVal = dacLeft; end
    if (dacRightStb) begin rightCount++; rightVal = dacRight; end
  end

  logic cap [256];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] capTag();
    logic [15:0] t;
    for (int j = 0; j < 16; j++) t[15-j] = cap[j];
    return t;
  endfunction

  function automatic logic [19:0] capSlot(input int k);
    logic [19:0] s;
    for (int p = 0; p < 20; p++) s[19-p] = cap[16 + (k-1)*20 + p];
    return s;
  endfunction

  // Drives one frame and captures the codec's outgoing frame. Entered at a negedge.
  task automatic runFrame(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4);
    logic [255:0] fr;
    fr = {tag, s1, s2, s3, s4, 160'd0};
    wrCount = 0; rdCount = 0; leftCount = 0; rightCount = 0;
    sync = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(posedge bitClk); #1;
      sdataOut = fr[255-i];
      if (i == 15) sync = 1'b0;
      @(negedge bitClk);
      cap[i] = sdataIn;
    end
  endtask

  task automatic checkReservedZero(input string req);
    logic [19:0] acc;
    acc = '0;
    for (int k = 5; k <= 12; k++) acc |= capSlot(k);
    chk(req, "slots 5-12 or-reduced", {12'd0, acc}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "sdataIn idle after reset", {31'd0, sdataIn}, 32'd0);
    chk("R4", "regWrEn idle", {31'd0, regWrEn}, 32'd0);
    chk("R5", "regRdEn idle", {31'd0, regRdEn}, 32'd0);
    chk("R8", "dac strobes idle", {30'd0, dacLeftStb, dacRightStb}, 32'd0);
    repeat (5) @(negedge bitClk);
    chk("R1", "sdataIn low before first sync", {31'd0, sdataIn}, 32'd0);
  endtask

  task automatic t_write();
    codecReady = 1'b1; recValid = 1'b0;
    runFrame(16'hE000, {1'b0, 7'h02, 12'd0}, {16'h1234, 4'd0}, 20'd0, 20'd0);
    chk("R4", "write count", wrCount, 1);
    chk("R4", "write address", {25'd0, wrAddr}, 32'h02);
    chk("R4", "write data", {16'd0, wrData}, 32'h1234);
    chk("R5", "no read on write", rdCount, 0);
    chk("R1", "outgoing tag, ready only", {16'd0, capTag()}, 32'h8000);
    chk("R7", "slot 1 zero without read", {12'd0, capSlot(1)}, 32'd0);
    chk("R7", "slot 2 zero without read", {12'd0, capSlot(2)}, 32'd0);
    chk("R9", "record slots zero when not valid", {12'd0, capSlot(3) | capSlot(4)}, 32'd0);
    checkReservedZero("R10");
  endtask

  task automatic t_readPcm();
    runFrame(16'hD800, {1'b1, 7'h26, 12'd0}, 20'd0, 20'hABCDE, 20'h12345);
    chk("R5", "read count", rdCount, 1);
    chk("R5", "read address", {25'd0, rdAddr}, 32'h26);
    chk("R4", "no write on read", wrCount, 0);
    chk("R8", "left strobe count", leftCount, 1);
    chk("R2,R8", "left word = bits 19..2", {14'd0, leftVal}, {14'd0, 18'(20'hABCDE >> 2)});
    chk("R8", "right strobe count", rightCount, 1);
    chk("R2,R8", "right word = bits 19..2", {14'd0, rightVal}, {14'd0, 18'(20'h12345 >> 2)});
    chk("R6", "no echo in request frame", {16'd0, capTag()}, 32'h8000);
  endtask

  task automatic t_echo();
    recValid = 1'b1; recLeft = 18'h2AAAA; recRight = 18'h15555;
    runFrame(16'h0000, 20'd0, 20'd0, 20'd0, 20'd0);
    chk("R6,R9", "tag with echo and record", {16'd0, capTag()}, 32'hF800);
    chk("R6", "echo index slot 1", {12'd0, capSlot(1)}, {12'd0, 1'b0, 7'h26, 12'd0});
    chk("R6", "echo data slot 2", {12'd0, capSlot(2)}, {12'd0, rdModel(7'h26), 4'd0});
    chk("R9", "left record slot", {12'd0, capSlot(3)}, {12'd0, 18'h2AAAA, 2'd0});
    chk("R9", "right record slot", {12'd0, capSlot(4)}, {12'd0, 18'h15555, 2'd0});
    checkReservedZero("R10");
    chk("R3", "invalid frame no strobes", wrCount + rdCount + leftCount + rightCount, 0);
  endtask

  task automatic t_gated();
    recValid = 1'b0;
    runFrame(16'h7800, {1'b0, 7'h05, 12'd0}, {16'hBEEF, 4'd0}, 20'hFFFFF, 20'hFFFFF);
    chk("R3", "frame-valid clear: no write", wrCount, 0);
    chk("R3", "frame-valid clear: no dac", leftCount + rightCount, 0);
    chk("R6", "echo lasts one frame", {16'd0, capTag()}, 32'h8000);
    chk("R7", "slot 1/2 zero again", {12'd0, capSlot(1) | capSlot(2)}, 32'd0);
  endtask

  task automatic t_partial();
    runFrame(16'hB000, {1'b0, 7'h09, 12'd0}, {16'hCAFE, 4'd0}, 20'h80004, 20'h7FFFF);
    chk("R4", "slot 1 invalid: no write", wrCount, 0);
    chk("R3", "only left flagged", leftCount, 1);
    chk("R3", "right not flagged", rightCount, 0);
    chk("R8", "left value", {14'd0, leftVal}, {14'd0, 18'h20001});
  endtask

  task automatic t_readWithData();
    runFrame(16'hE000, {1'b1, 7'h11, 12'd0}, {16'h5555, 4'd0}, 20'd0, 20'd0);
    chk("R4", "read flag blocks write", wrCount, 0);
    chk("R5", "read issued", rdCount, 1);
    codecReady = 1'b0;
    runFrame(16'h0000, 20'd0, 20'd0, 20'd0, 20'd0);
    chk("R9", "ready clear, echo set", {16'd0, capTag()}, 32'h6000);
    chk("R6", "echo index 0x11", {12'd0, capSlot(1)}, {12'd0, 1'b0, 7'h11, 12'd0});
    chk("R6", "echo data 0x11", {12'd0, capSlot(2)}, {12'd0, rdModel(7'h11), 4'd0});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge bitClk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge bitClk);
    t_reset();
    t_write();
    t_readPcm();
    t_echo();
    t_gated();
    t_partial();
    t_readWithData();
    repeat (4) @(negedge bitClk);
    finished = 1;
    summary();
    $finish;
  end
endmodule